// File: doc/BRIEF.md
# Retimer Power and Reset Sequencer

This block drives the supply enable and the active-low reset of an external signal retimer. It watches two level inputs: one says a cable is attached, the other asks to keep the retimer powered regardless of attachment. When a cable arrives, supply comes up first and reset is let go one programmed delay later. When the cable leaves, reset goes back in first and supply is removed one programmed delay later. The same delay value serves both directions.

The delay is an 8-bit count of milliseconds. It is timed by a prescaler that counts pulses of a microsecond clock-enable input, with `TICKS_PER_MS` pulses to a millisecond. Both level inputs cross into the clock domain through two-flop synchronizers. Both outputs leave straight from flops.

Top module: `retimer_pwr_seq`

## Requirements
- R1: In steady state `pwr_en` is high when the attach input or the force input is high, and low when both are low. Dropping the force input while detached lowers `pwr_en`.
- R2: `rst_n_out` is high only while attached. The force input never releases reset.
- R3: On attach, `pwr_en` rises first. `rst_n_out` rises N*T+1 clock cycles later, where N is `delay_ms` and T is `TICKS_PER_MS`, provided `us_tick` is high every cycle. `rst_n_out` is never high while `pwr_en` is low.
- R4: On detach with force low, `rst_n_out` falls first. `pwr_en` falls N*T+1 cycles later.
- R5: With `delay_ms` = 0, the second edge follows the first by exactly one cycle in both directions.
- R6: On detach with force high, `rst_n_out` falls and `pwr_en` stays high with no delayed drop.
- R7: If attach returns during the detach delay, `pwr_en` stays high. `rst_n_out` rises N*T+1 cycles after the block sees the new attach.
- R8: The delay prescaler advances only on cycles where `us_tick` is high.
- R9: A change on an input reaches an output on the third rising edge after it is applied: two synchronizer flops plus the output flop.
- R10: While `rst` is high, and on the first edge after it rises, both outputs are low, whatever the input levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_tick | input | 1 | Microsecond clock-enable pulse |
| attach_in | input | 1 | Cable attached level (asynchronous) |
| force_pwr_in | input | 1 | Keep-powered override level (asynchronous) |
| delay_ms | input | 8 | Delay between the two edges, in milliseconds |
| pwr_en | output | 1 | Retimer supply enable |
| rst_n_out | output | 1 | Retimer reset, active low |

## Verification
The hardest case to reach is a re-attach that lands inside the detach delay. The input must return after the synchronizers have passed on the detach, but before the countdown ends. The bench counts cycles from the detach and drives attach back five cycles later. It then checks that supply never drops and that reset is released only after a full fresh delay. A second hard case runs the microsecond tick at half rate. It shows that the delay stretches rather than counting clock cycles.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_UP_WAIT = 2'd1,
    ST_ON      = 2'd2,
    ST_DN_WAIT = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rps_delay_timer.sv
module rps_delay_timer #(
  parameter int DELAY_W      = 8,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               run,
  input  logic [DELAY_W-1:0] delay_val,
  input  logic               us_tick,
  output logic               done
);
  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

  logic [PRE_W-1:0]   pre_q;
  logic [DELAY_W-1:0] remain_q;
  logic               active;

  assign active = run && us_tick && (remain_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      remain_q <= '0;
    end else if (load) begin
      pre_q    <= '0;
      remain_q <= delay_val;
    end else if (active) begin
      if (pre_q == PRE_LAST) begin
        pre_q    <= '0;
        remain_q <= remain_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign done = (remain_q == '0);
endmodule

// File: rtl/retimer_pwr_seq.sv
module retimer_pwr_seq #(
  parameter int DELAY_W      = 8,
  parameter int TICKS_PER_MS = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               us_tick,
  input  logic               attach_in,
  input  logic               force_pwr_in,
  input  logic [DELAY_W-1:0] delay_ms,
  output logic               pwr_en,
  output logic               rst_n_out
);
  import rps_pkg::*;

  logic [1:0]  sync_q;
  logic        att_s, frc_s;
  seq_state_t  state_q, state_d;
  logic        load, run, done;
  logic        pwr_q, rstn_q;

  rps_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({force_pwr_in, attach_in}),
    .q   (sync_q)
  );
  assign att_s = sync_q[0];
  assign frc_s = sync_q[1];

  assign run = (state_q == ST_UP_WAIT) || (state_q == ST_DN_WAIT);

  rps_delay_timer #(.DELAY_W(DELAY_W), .TICKS_PER_MS(TICKS_PER_MS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .run       (run),
    .delay_val (delay_ms),
    .us_tick   (us_tick),
    .done      (done)
  );

  // Sequencing: supply before reset release, reset before supply removal.
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (att_s) begin
          state_d = ST_UP_WAIT;
          load    = 1'b1;
        end
      end
      ST_UP_WAIT: begin
        if (!att_s) begin
          if (frc_s) state_d = ST_OFF;
          else begin
            state_d = ST_DN_WAIT;
            load    = 1'b1;
          end
        end else if (done) begin
          state_d = ST_ON;
        end
      end
      ST_ON: begin
        if (!att_s) begin
          if (frc_s) state_d = ST_OFF;
          else begin
            state_d = ST_DN_WAIT;
            load    = 1'b1;
          end
        end
      end
      ST_DN_WAIT: begin
        if (att_s) begin
          state_d = ST_UP_WAIT;
          load    = 1'b1;
        end else if (frc_s || done) begin
          state_d = ST_OFF;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      pwr_q   <= 1'b0;
      rstn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pwr_q   <= (state_d != ST_OFF) || frc_s;
      rstn_q  <= (state_d == ST_ON);
    end
  end

  assign pwr_en    = pwr_q;
  assign rst_n_out = rstn_q;
endmodule

// File: rtl/retimer_pwr_seq_chk.sv
module retimer_pwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic attach_in,
  input logic force_pwr_in,
  input logic pwr_en,
  input logic rst_n_out
);
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
  end

  assert_reset_low_R10: assert property (@(posedge clk)
    $past(rst) |-> (!pwr_en && !rst_n_out));

  assert_rst_needs_pwr_R3: assert property (@(posedge clk) disable iff (rst)
    rst_n_out |-> pwr_en);

  assert_release_after_pwr_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_out) |-> $past(pwr_en));

  assert_drop_after_reset_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> !$past(rst_n_out));

  assert_force_holds_pwr_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && force_pwr_in && $past(force_pwr_in) &&
     $past(force_pwr_in, 2) && $past(force_pwr_in, 3)) |-> pwr_en);

  assert_detached_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && !attach_in && !$past(attach_in) &&
     !$past(attach_in, 2) && !$past(attach_in, 3)) |-> !rst_n_out);
endmodule

bind retimer_pwr_seq retimer_pwr_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .attach_in    (attach_in),
  .force_pwr_in (force_pwr_in),
  .pwr_en       (pwr_en),
  .rst_n_out    (rst_n_out)
);

// File: tb/retimer_pwr_seq_test.sv
module retimer_pwr_seq_test;
  localparam int T = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       us_tick = 1'b1;
  logic       attach_in = 1'b0;
  logic       force_pwr_in = 1'b0;
  logic [7:0] delay_ms = 8'd2;
  logic       pwr_en, rst_n_out;
  logic       tick_half = 1'b0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  retimer_pwr_seq #(.TICKS_PER_MS(T)) uut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .attach_in(attach_in),
    .force_pwr_in(force_pwr_in), .delay_ms(delay_ms),
    .pwr_en(pwr_en), .rst_n_out(rst_n_out)
  );

  initial begin
    forever begin
      @(negedge clk);
      us_tick = tick_half ? ~us_tick : 1'b1;
    end
  end

  task automatic chk(input logic ep, input logic er, input int req, input string what);
    checks++;
    if (pwr_en !== ep || rst_n_out !== er) begin
      errors++;
      $display("FAIL R%0d %s: pwr_en=%b rst_n_out=%b expected %b %b",
               req, what, pwr_en, rst_n_out, ep, er);
    end
  endtask

  // {attach, force, delay[7:0], wait[7:0], exp_pwr, exp_rstn, req[3:0]}
  localparam int NV = 17;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd2, 8'd3,  1'b0, 1'b0, 4'd1},  // R1 idle
    {1'b1, 1'b0, 8'd2, 8'd2,  1'b0, 1'b0, 4'd9},  // R9 not yet
    {1'b1, 1'b0, 8'd2, 8'd1,  1'b1, 1'b0, 4'd9},  // R9 third edge
    {1'b1, 1'b0, 8'd2, 8'd8,  1'b1, 1'b0, 4'd3},  // R3 just before release
    {1'b1, 1'b0, 8'd2, 8'd1,  1'b1, 1'b1, 4'd3},  // R3 release at N*T+1
    {1'b0, 1'b0, 8'd2, 8'd3,  1'b1, 1'b0, 4'd4},  // R4 reset first
    {1'b0, 1'b0, 8'd2, 8'd8,  1'b1, 1'b0, 4'd4},  // R4 still powered
    {1'b0, 1'b0, 8'd2, 8'd1,  1'b0, 1'b0, 4'd4},  // R4 power off
    {1'b0, 1'b1, 8'd2, 8'd3,  1'b1, 1'b0, 4'd1},  // R1 force alone
    {1'b1, 1'b1, 8'd2, 8'd12, 1'b1, 1'b1, 4'd2},  // R2 attach releases
    {1'b0, 1'b1, 8'd2, 8'd3,  1'b1, 1'b0, 4'd6},  // R6 reset, power held
    {1'b0, 1'b1, 8'd2, 8'd12, 1'b1, 1'b0, 4'd6},  // R6 no delayed drop
    {1'b0, 1'b0, 8'd2, 8'd3,  1'b0, 1'b0, 4'd1},  // R1 force removed
    {1'b1, 1'b0, 8'd0, 8'd3,  1'b1, 1'b0, 4'd5},  // R5 power up
    {1'b1, 1'b0, 8'd0, 8'd1,  1'b1, 1'b1, 4'd5},  // R5 one cycle later
    {1'b0, 1'b0, 8'd0, 8'd3,  1'b1, 1'b0, 4'd5},  // R5 reset first
    {1'b0, 1'b0, 8'd0, 8'd1,  1'b0, 1'b0, 4'd5}   // R5 one cycle later
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset dominates active inputs
    attach_in = 1'b1;
    force_pwr_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(1'b0, 1'b0, 10, "outputs during reset");
    attach_in = 1'b0;
    force_pwr_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(1'b0, 1'b0, 10, "after reset release");

    for (int i = 0; i < NV; i++) begin
      attach_in    = VEC[i][23];
      force_pwr_in = VEC[i][22];
      delay_ms     = VEC[i][21:14];
      repeat (int'(VEC[i][13:6])) @(negedge clk);
      chk(VEC[i][5], VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R7: re-attach during the detach delay
    delay_ms = 8'd2;
    attach_in = 1'b1;
    repeat (14) @(negedge clk);
    chk(1'b1, 1'b1, 7, "attached before detach");
    attach_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(1'b1, 1'b0, 7, "detach began");
    repeat (2) @(negedge clk);
    attach_in = 1'b1;
    repeat (8) @(negedge clk);
    chk(1'b1, 1'b0, 7, "no drop where old delay ended");
    repeat (3) @(negedge clk);
    chk(1'b1, 1'b0, 7, "full new delay not yet over");
    @(negedge clk);
    chk(1'b1, 1'b1, 7, "release after full new delay");

    // R10: reset while active
    rst = 1'b1;
    @(negedge clk);
    chk(1'b0, 1'b0, 10, "reset mid-operation");
    attach_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R8: half-rate microsecond tick stretches the delay
    tick_half = 1'b1;
    delay_ms = 8'd1;
    attach_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(1'b1, 1'b0, 8, "power with slow tick");
    repeat (5) @(negedge clk);
    chk(1'b1, 1'b0, 8, "held past full-rate delay");
    repeat (9) @(negedge clk);
    chk(1'b1, 1'b1, 8, "released after slow delay");
    tick_half = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule